// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block produces the word address presented to a synchronous burst memory. A burst begins when either of two independent start strobes is seen while the chip-enable qualifier is active. On that clock edge the external address is captured. After that, the two least significant address bits step through a four-word block each time the advance input is high. The upper address bits stay fixed until the next load.

The order of the four beats is chosen at run time by `order_linear`. A high level gives linear order: add one, wrap modulo 4. A low level gives interleaved order: the loaded low bits XOR the beat count. Tying the pin low therefore selects interleaved order by default.

Bursting is optional. A fresh external address may be loaded on every clock with no lost cycle. The address register adds one clock before the first access. The memory array then gives the first word after two clocks and each later beat after one clock.

Top module: `burst_addr_seq`

## Requirements
- R1: Bits above the two lowest bits of `cur_addr` change only on a clock edge where a load is accepted. Stepping from low bits 3 to 0, or any other wrap, leaves them unchanged.
- R2: A load is accepted when `start_a` or `start_b` is high together with `chip_en`. Either strobe alone is enough. After that edge, `cur_addr` equals the captured `ext_addr` and `burst_active` is 1.
- R3: While `burst_active` is 1, `chip_en` is high, no strobe is high and `advance` is low, `cur_addr` holds its value.
- R4: With `order_linear` = 1, each accepted advance sets the low two bits to (loaded low bits + k) mod 4, where k is the number of advances since the load.
- R5: With `order_linear` = 0 (interleaved, the tie-low default), each accepted advance sets the low two bits to (loaded low bits XOR (k mod 4)).
- R6: When a strobe and `advance` are high together with `chip_en`, the load wins. `cur_addr` becomes `ext_addr` and the beat count restarts at 0.
- R7: When `chip_en` is low, strobes and `advance` are ignored, `cur_addr` holds, and `burst_active` is 0 after that edge.
- R8: Loads on consecutive clocks each appear on `cur_addr` one clock after their strobe, with no gap.
- R9: A synchronous reset (`rst` high at an edge) sets `cur_addr` to 0 and `burst_active` to 0.
- R10: When `burst_active` is 0 and no load is accepted, `advance` has no effect on `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address captured on a load |
| start_a | input | 1 | First burst start strobe |
| start_b | input | 1 | Second burst start strobe |
| advance | input | 1 | Step to the next beat of the burst |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| chip_en | input | 1 | Synchronous qualifier for strobes and advance |
| cur_addr | output | ADDR_W | Current internal word address |
| burst_active | output | 1 | A loaded burst is in progress |

## Verification
A wrong beat count or a wrong stored base shows up on the low two bits of `cur_addr` one clock after the first advance that uses it. Running all four start offsets in both orders, through more than four beats, exposes any wrong wrap or ordering within at most five clocks of the load. A carry leaking into the upper bits, a lost strobe, or a lost priority of load over advance is visible on the very next edge. A flag that fails to clear is visible when an advance after a chip-enable drop moves the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_INTERLEAVED = 1'b0,
        ORDER_LINEAR      = 1'b1
    } order_e;

    typedef struct packed {
        beat_t base;
        beat_t cnt;
    } beat_state_t;

    function automatic beat_t beat_addr(beat_t base, beat_t cnt, order_e ord);
        beat_t sum;
        sum = base + cnt;
        return (ord == ORDER_LINEAR) ? sum : (base ^ cnt);
    endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start_a,
    input  logic start_b,
    input  logic advance,
    input  logic chip_en,
    output logic load,
    output logic step,
    output logic active
);

    assign load = (start_a | start_b) & chip_en;
    assign step = advance & active & chip_en & ~load;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
        end else if (!chip_en) begin
            active <= 1'b0;
        end
    end

    // R7: a dropped qualifier clears the flag on the next edge
    assert_ce_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !active);

    // R2: either strobe with the qualifier raises the flag
    assert_load_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ((start_a || start_b) && chip_en) |=> active);

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
    import burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  beat_t  ext_lo,
    input  order_e ord,
    output beat_t  low
);

    beat_state_t st;
    beat_t       cnt_nxt;

    always_comb begin
        cnt_nxt = st.cnt + beat_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            low <= '0;
        end else if (load) begin
            st.base <= ext_lo;
            st.cnt  <= '0;
            low     <= ext_lo;
        end else if (step) begin
            st.cnt <= cnt_nxt;
            low    <= beat_addr(st.base, cnt_nxt, ord);
        end
    end

endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
    parameter int UPPER_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [UPPER_W-1:0] ext_hi,
    output logic [UPPER_W-1:0] hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
        end else if (load) begin
            hi <= ext_hi;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              advance,
    input  logic              order_linear,
    input  logic              chip_en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic               load;
    logic               step;
    beat_t              low;
    logic [UPPER_W-1:0] hi;

    burst_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_a (start_a),
        .start_b (start_b),
        .advance (advance),
        .chip_en (chip_en),
        .load    (load),
        .step    (step),
        .active  (burst_active)
    );

    burst_beat_gen u_beat (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .ext_lo (ext_addr[BEAT_W-1:0]),
        .ord    (order_e'(order_linear)),
        .low    (low)
    );

    burst_upper_reg #(.UPPER_W(UPPER_W)) u_upper (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .ext_hi (ext_addr[ADDR_W-1:BEAT_W]),
        .hi     (hi)
    );

    assign cur_addr = {hi, low};

    // R1: upper bits move only with an accepted load
    assert_upper_fixed_R1: assert property (@(posedge clk) disable iff (rst)
        !((start_a || start_b) && chip_en) |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

    // R2 / R8: captured address appears on the next edge
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
        ((start_a || start_b) && chip_en) |=> cur_addr == $past(ext_addr));

    // R3: no advance, no load: hold
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (burst_active && chip_en && !start_a && !start_b && !advance)
        |=> $stable(cur_addr));

    // R6: load wins over advance
    assert_load_priority_R6: assert property (@(posedge clk) disable iff (rst)
        ((start_a || start_b) && chip_en && advance) |=> cur_addr == $past(ext_addr));

    // R7: qualifier low freezes the address
    assert_ce_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> $stable(cur_addr));

    // R10: advance without an active burst does nothing
    assert_idle_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (!burst_active && !((start_a || start_b) && chip_en)) |=> $stable(cur_addr));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              start_a = 1'b0;
    logic              start_b = 1'b0;
    logic              advance = 1'b0;
    logic              order_linear = 1'b0;
    logic              chip_en = 1'b0;
    logic [ADDR_W-1:0] cur_addr;
    logic              burst_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [ADDR_W-1:0] m_addr;
    logic              m_act;
    logic [1:0]        m_base;
    logic [1:0]        m_cnt;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .ext_addr     (ext_addr),
        .start_a      (start_a),
        .start_b      (start_b),
        .advance      (advance),
        .order_linear (order_linear),
        .chip_en      (chip_en),
        .cur_addr     (cur_addr),
        .burst_active (burst_active)
    );

    task automatic check(string req);
        checks++;
        if (cur_addr !== m_addr || burst_active !== m_act) begin
            fails++;
            $display("FAIL %s: addr=%h exp=%h active=%b exp=%b",
                     req, cur_addr, m_addr, burst_active, m_act);
        end
    endtask

    task automatic cyc(string req, logic a, logic b, logic adv, logic ce,
                       logic lin, logic [ADDR_W-1:0] ea);
        logic ld;
        @(negedge clk);
        start_a = a; start_b = b; advance = adv; chip_en = ce;
        order_linear = lin; ext_addr = ea;
        @(posedge clk);
        ld = (a | b) & ce;
        if (ld) begin
            m_addr = ea; m_base = ea[1:0]; m_cnt = 2'd0; m_act = 1'b1;
        end else if (!ce) begin
            m_act = 1'b0;
        end else if (adv && m_act) begin
            m_cnt = m_cnt + 2'd1;
            m_addr[1:0] = lin ? (m_base + m_cnt) : (m_base ^ m_cnt);
        end
        #1;
        check(req);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: addr=%h exp=%h active=%b exp=%b",
                     cur_addr, m_addr, burst_active, m_act);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_addr = '0; m_act = 1'b0; m_base = '0; m_cnt = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R9");
        @(negedge clk);
        rst = 1'b0;

        // R4 / R5 / R1: every start offset, both orders, six advances with holds
        for (int ord = 0; ord < 2; ord++) begin
            for (int lo = 0; lo < 4; lo++) begin
                logic [ADDR_W-1:0] base;
                base = ADDR_W'(8'hB4 + lo + ord * 8'h10);
                cyc("R2", (lo % 2) == 0, (lo % 2) == 1, 1'b0, 1'b1, ord[0], base);
                for (int k = 0; k < 6; k++) begin
                    cyc(ord ? "R4" : "R5", 1'b0, 1'b0, 1'b1, 1'b1, ord[0], 8'h00);
                    if (k == 2) cyc("R3", 1'b0, 1'b0, 1'b0, 1'b1, ord[0], 8'hFF);
                end
                cyc("R1", 1'b0, 1'b0, 1'b1, 1'b1, ord[0], 8'h00);
            end
        end

        // R6: strobe plus advance loads
        cyc("R2", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3D);
        cyc("R4", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        cyc("R6", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h52);
        cyc("R6", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h67);
        cyc("R5", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);

        // R7 then R10: qualifier drop, then advances on an idle sequencer
        cyc("R7", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hEE);
        cyc("R7", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11);
        cyc("R10", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h22);
        cyc("R10", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h33);

        // R8: back-to-back loads, alternating strobes
        for (int i = 0; i < 32; i++) begin
            cyc("R8", (i % 3) != 1, (i % 3) != 0, i[0], 1'b1, i[1], ADDR_W'(i * 37 + 5));
        end

        // R9: reset in the middle of a burst
        cyc("R4", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        m_addr = '0; m_act = 1'b0; m_base = '0; m_cnt = '0;
        #1;
        check("R9");
        @(negedge clk);
        rst = 1'b0;
        cyc("R10", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule